// File: doc/BRIEF.md
# Hot-Swap Power Mode Sequencer

This block is the digital control core of a hot-swap switch controller. It decides when an external pass transistor may be switched on. The analog parts are reduced to digital inputs: the gate-voltage comparators, the sampled over/undervoltage result, the circuit-breaker comparator and the current-fault latch with its timer. A 1 µs tick enable marks time. The block drives a gate pull-up enable, a slow gate pull-down enable, a status line that is released once the switch is fully on, and a 3-bit mode code.

Every power-up and every recovery passes through a debounce of `DEB_TICKS` ticks (40 ms by default). A voltage fault cancels the debounce. The gate ramps up only after a clean debounce. Status is latched high the first time the gate reaches its high threshold. Any shutdown or fault clears it.

Top module: `hotswap_seq`

## Requirements
- R1: The mode code is 0 shutdown, 1 debounce, 2 start-up, 3 normal-on, 4 overcurrent, 5 voltage fault, 6 current fault. After reset the mode is 0, the pull-down is on, the pull-up is off and status is low. The pull-up and pull-down are never on together.
- R2: In shutdown, with enable high and supply above lockout, the block enters debounce on the next clock edge.
- R3: Debounce lasts exactly `DEB_TICKS` tick pulses, however they are spaced. On the edge that takes the last tick, the mode becomes start-up. Clock cycles without a tick do not advance the count.
- R4: A voltage-fault flag seen during debounce moves the block to voltage-fault mode and discards the partial count. When the flag clears, the block enters debounce on the next edge, and a full `DEB_TICKS` ticks are needed again.
- R5: In start-up the pull-up is on and status is low. When the gate-high input is asserted, the block enters normal-on and status is released (1) on the same edge.
- R6: Once released, status stays 1 in normal-on even when the gate-high input drops.
- R7: In start-up or normal-on, a circuit-breaker trip enters overcurrent with the pull-up still on. When the trip clears, the block returns to normal-on if status was already released, and otherwise to start-up.
- R8: A set current-fault latch in start-up, normal-on or overcurrent enters current-fault mode. That mode turns the gate off and clears status. The block leaves it for debounce only when the latch is clear and the timer-discharged input is high.
- R9: A voltage fault in start-up, normal-on or overcurrent enters voltage-fault mode, turns the gate off and clears status on the next edge.
- R10: Enable low or supply below lockout turns the pull-up off, turns the pull-down on and forces status low at once. The mode becomes shutdown only on an edge where the gate-low input is asserted. Until then the mode holds.
- R11: In shutdown, with enable low, neither the tick input nor the voltage-fault flag changes the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable, one pulse per microsecond |
| en | input | 1 | Enable request |
| supply_ok | input | 1 | Supply above lockout |
| vfault | input | 1 | Sampled over/undervoltage flag |
| oc_trip | input | 1 | Circuit-breaker comparator tripped |
| cf_latch | input | 1 | Current-fault latch set |
| tmr_dis | input | 1 | Fault timer discharged |
| gate_hi | input | 1 | Gate above its high threshold |
| gate_lo | input | 1 | Gate below its low threshold |
| gate_up | output | 1 | Gate pull-up enable |
| gate_dn | output | 1 | Gate slow pull-down enable |
| stat_rel | output | 1 | Status released (1 = high impedance, 0 = pulled low) |
| mode | output | 3 | Mode code |

## Verification
The bench builds the block with `DEB_TICKS` = 4. At that size the whole debounce window can be swept. Every tick spacing from back-to-back up to three idle cycles is checked against an exact count of tick pulses. A voltage fault is injected after every possible partial count from 0 to 3, followed each time by a full recount. The short window also leaves room in the run to walk each fault path from start-up, normal-on and overcurrent, and to cover the gate-low-gated entry into shutdown.

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int DEB_TICKS = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       supply_ok,
  input  logic       vfault,
  input  logic       oc_trip,
  input  logic       cf_latch,
  input  logic       tmr_dis,
  input  logic       gate_hi,
  input  logic       gate_lo,
  output logic       gate_up,
  output logic       gate_dn,
  output logic       stat_rel,
  output logic [2:0] mode
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] DEB_LAST = CW'(DEB_TICKS - 1);

  typedef enum logic [2:0] {
    M_SHD = 3'd0, M_DEB = 3'd1, M_SU = 3'd2, M_NORM = 3'd3,
    M_OC = 3'd4, M_VF = 3'd5, M_CF = 3'd6
  } mode_t;

  mode_t st, nxt;
  logic [CW-1:0] cnt;
  logic stat_q;

  wire off    = !en || !supply_ok;
  wire active = (st == M_SU) || (st == M_NORM) || (st == M_OC);

  always_comb begin
    nxt = st;
    if (off) begin
      if (gate_lo) nxt = M_SHD;
    end else begin
      case (st)
        M_SHD: nxt = M_DEB;
        M_DEB: if (vfault) nxt = M_VF;
               else if (tick && cnt == DEB_LAST) nxt = M_SU;
        M_SU, M_NORM, M_OC:
          if (vfault) nxt = M_VF;
          else if (cf_latch) nxt = M_CF;
          else if (oc_trip) nxt = M_OC;
          else if (st == M_OC) nxt = stat_q ? M_NORM : M_SU;
          else if (st == M_SU && gate_hi) nxt = M_NORM;
        M_VF:  if (!vfault) nxt = M_DEB;
        M_CF:  if (!cf_latch && tmr_dis) nxt = M_DEB;
        default: nxt = M_SHD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= M_SHD;
      cnt    <= '0;
      stat_q <= 1'b0;
    end else begin
      st <= nxt;
      if (off || st != M_DEB || vfault) cnt <= '0;
      else if (tick) cnt <= (cnt == DEB_LAST) ? '0 : cnt + 1'b1;
      if (off || (active && (vfault || cf_latch))) stat_q <= 1'b0;
      else if ((st == M_SU || st == M_OC) && gate_hi) stat_q <= 1'b1;
    end
  end

  assign gate_up  = !off && active;
  assign gate_dn  = !gate_up;
  assign stat_rel = stat_q && !off;
  assign mode     = st;

  assert_drive_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_up && gate_dn));
  assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_SHD && !off) |=> (st == M_DEB));
  assert_deb_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_DEB && !off && vfault) |=> (st == M_VF && cnt == '0));
  assert_stat_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> ($past(st) == M_SU || $past(st) == M_OC));
  assert_cf_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_CF && !off && cf_latch) |=> (st == M_CF));
  assert_vf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !off && vfault) |=> (st == M_VF && !stat_q));
  assert_off_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !gate_lo) |=> $stable(st));
endmodule

// File: tb/hotswap_seq_test.sv
module hotswap_seq_test;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, en = 0, supply_ok = 1, vfault = 0, oc_trip = 0;
  logic cf_latch = 0, tmr_dis = 1, gate_hi = 0, gate_lo = 1;
  logic gate_up, gate_dn, stat_rel;
  logic [2:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  hotswap_seq #(.DEB_TICKS(N)) uut (.*);

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(int gap);
    tick = 1; step(); tick = 0;
    repeat (gap) step();
  endtask

  task automatic to_shd();
    en = 0; gate_lo = 1; gate_hi = 0; vfault = 0; oc_trip = 0; cf_latch = 0;
    step(); chk("R10 to shutdown", mode, 0);
  endtask

  task automatic to_norm();
    en = 1; step();
    repeat (N) pulse(0);
    chk("R3 start-up reached", mode, 2);
    gate_hi = 1; step(); gate_hi = 0;
    chk("R5 normal-on", mode, 3);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); rst_n = 1; step();
    chk("R1 reset mode", mode, 0);
    chk("R1 reset pull-down", gate_dn, 1);
    chk("R1 reset pull-up", gate_up, 0);
    chk("R1 reset status", stat_rel, 0);

    // R11: shutdown ignores tick and vfault while disabled
    vfault = 1; repeat (3) pulse(1); vfault = 0;
    chk("R11 shutdown hold", mode, 0);

    // R2/R3: tick spacing sweep
    for (int g = 0; g < 4; g++) begin
      en = 1; step();
      chk("R2 enter debounce", mode, 1);
      repeat (g) step();
      chk("R3 idle cycles no advance", mode, 1);
      for (int k = 0; k < N - 1; k++) pulse(g);
      chk("R3 before last tick", mode, 1);
      chk("R1 debounce pull-down", gate_dn, 1);
      tick = 1; step(); tick = 0;
      chk("R3 on last tick", mode, 2);
      chk("R5 start-up pull-up", gate_up, 1);
      chk("R5 start-up status low", stat_rel, 0);
      to_shd();
    end

    // R4: voltage fault after every partial count
    for (int j = 0; j < N; j++) begin
      en = 1; step();
      for (int k = 0; k < j; k++) pulse(0);
      chk("R4 partial debounce", mode, 1);
      vfault = 1; step();
      chk("R4 vfault mode", mode, 5);
      chk("R4 vfault pull-down", gate_dn, 1);
      pulse(0);
      chk("R4 held in vfault", mode, 5);
      vfault = 0; step();
      chk("R4 back to debounce", mode, 1);
      for (int k = 0; k < N - 1; k++) pulse(0);
      chk("R4 full recount needed", mode, 1);
      pulse(0);
      chk("R4 start-up after recount", mode, 2);
      to_shd();
    end

    // R5/R6: status latch
    to_norm();
    chk("R5 status released", stat_rel, 1);
    repeat (3) step();
    chk("R6 status held", stat_rel, 1);
    chk("R6 still normal", mode, 3);

    // R7: overcurrent from normal-on
    oc_trip = 1; step();
    chk("R7 overcurrent mode", mode, 4);
    chk("R7 pull-up kept", gate_up, 1);
    chk("R7 status kept", stat_rel, 1);
    oc_trip = 0; step();
    chk("R7 back to normal", mode, 3);

    // R8: current fault from overcurrent
    oc_trip = 1; step(); cf_latch = 1; step();
    chk("R8 current fault mode", mode, 6);
    chk("R8 status cleared", stat_rel, 0);
    chk("R8 pull-down", gate_dn, 1);
    oc_trip = 0; tmr_dis = 0; step();
    chk("R8 held while latched", mode, 6);
    cf_latch = 0; step();
    chk("R8 held until discharged", mode, 6);
    tmr_dis = 1; step();
    chk("R8 to debounce", mode, 1);
    to_shd();

    // R7: overcurrent from start-up returns to start-up
    en = 1; step(); repeat (N) pulse(0);
    oc_trip = 1; step();
    chk("R7 overcurrent from start-up", mode, 4);
    oc_trip = 0; step();
    chk("R7 back to start-up", mode, 2);
    chk("R7 status still low", stat_rel, 0);
    to_shd();

    // R9: voltage fault in normal-on
    to_norm();
    vfault = 1; step();
    chk("R9 vfault mode", mode, 5);
    chk("R9 status cleared", stat_rel, 0);
    chk("R9 gate off", gate_up, 0);
    vfault = 0; step();
    chk("R9 vfault exits to debounce", mode, 1);
    to_shd();

    // R10: disable with gate not yet low
    to_norm();
    gate_lo = 0; en = 0; #1;
    chk("R10 pull-up off at once", gate_up, 0);
    chk("R10 pull-down on at once", gate_dn, 1);
    chk("R10 status low at once", stat_rel, 0);
    step(); step();
    chk("R10 mode held", mode, 3);
    gate_lo = 1; step();
    chk("R10 shutdown on gate low", mode, 0);

    // R10: supply lockout
    to_norm();
    gate_lo = 0; supply_ok = 0; step();
    chk("R10 lockout hold", mode, 3);
    chk("R10 lockout status", stat_rel, 0);
    gate_lo = 1; step();
    chk("R10 lockout shutdown", mode, 0);
    supply_ok = 1; en = 1; step();
    chk("R6 status not restored", stat_rel, 0);
    to_shd();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule